// File: doc/BRIEF.md
# UART Receive Descriptor Ring Engine

This block sits behind a UART receiver front end and moves each received character into a ring of receive buffers. Every buffer has one 32-bit descriptor word in an on-chip descriptor store. Each buffer slot is `BUF_BYTES` bytes in a separate byte store. The engine fills the buffer of the current descriptor and then closes it. A buffer closes when it reaches its length limit, on a character error, on a break, or after a run of idle periods. On close the engine writes the byte count and the cause flags back into the descriptor, raises the receive event if the descriptor asks for one, and moves to the next descriptor in the ring.

Characters arrive on a valid/ready stream. A byte transfers in any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle after each close, while the descriptor is written back. The front end must then hold `in_valid` and its byte until `in_ready` returns. Break and idle indications are single-cycle strobes. The engine holds them internally and acts on them in a cycle when no byte is offered. A host port with one-cycle read latency gives access to both stores: `host_sel` 0 selects descriptors and 1 selects buffer bytes. The host hands a descriptor to the engine by setting its empty flag.

Descriptor word layout. Bits 31:16 hold the byte count. The control bits are: bit 0 empty (E), bit 1 wrap (W), bit 2 interrupt (I), bit 3 continuous (CM). The status bits are: bit 8 idle close (ID), bit 9 break (BR), bit 10 framing (FR), bit 11 parity (PR), bit 12 overrun (OV).

Top module: `rxbd_rx_engine`

## Requirements
- R1: A byte taken on a handshake while the current descriptor has E=1 is stored at byte address `bd*BUF_BYTES + count`, and the count then rises by one.
- R2: When the count reaches the limit, the buffer closes. The limit is `max_len`, or `BUF_BYTES` when `max_len` is 0 or greater than `BUF_BYTES`. On close, bits 31:16 get the count, old status bits are cleared, and W, I and CM are kept.
- R3: After a close, the next descriptor is `ring_base` if W (bit 1) was set. Otherwise it is the following index, modulo `NUM_BD`.
- R4: With CM (bit 3) set, E (bit 0) stays 1 after a close, so the same buffer is refilled on the next pass. A close that carries FR, PR or OV always clears E. Without CM, E is cleared on every close.
- R5: A close of a descriptor with I (bit 2) set sets the sticky `evt_rx`. `irq` is high when (`evt_rx` and `irq_mask[0]`) or (`evt_busy` and `irq_mask[1]`). `evt_clr[0]` clears `evt_rx` and `evt_clr[1]` clears `evt_busy`.
- R6: A byte flagged `in_frame_err` is stored as the last byte, sets FR (bit 10) and closes the buffer.
- R7: A byte flagged `in_parity_err` is stored as the last byte, sets PR (bit 11) and closes the buffer.
- R8: A byte flagged `in_overrun` is stored without closing. The later close of that buffer sets OV (bit 12).
- R9: A `rx_break` strobe closes the current buffer with BR (bit 9). The count is the bytes held so far, which may be zero.
- R10: After `idle_limit` consecutive `rx_idle` strobes, with at least one byte in the buffer, the buffer closes with ID (bit 8). Any taken byte restarts the idle count. `idle_limit` = 0 disables idle closing.
- R11: If the current descriptor has E=0, an offered byte or a break is dropped. `evt_busy` is set and no store changes. Each later byte checks the same descriptor again, until the host sets E.
- R12: `in_ready` is low for exactly the one cycle after a close decision and high otherwise.
- R13: A host read returns its word on `host_rdata` one cycle after the request. Byte reads return the byte in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte offered |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Received byte |
| in_frame_err | input | 1 | Byte had no stop bit |
| in_parity_err | input | 1 | Byte failed parity |
| in_overrun | input | 1 | Receiver overran before this byte |
| rx_break | input | 1 | Break seen (strobe) |
| rx_idle | input | 1 | One idle period seen (strobe) |
| ring_base | input | BDW | Index of the first descriptor of the ring |
| max_len | input | LW | Buffer length limit (0 = full slot) |
| idle_limit | input | IDW | Idle periods before closing (0 = off) |
| irq_mask | input | 2 | Bit 0 receive, bit 1 busy |
| evt_clr | input | 2 | Clear strobes for the events |
| evt_rx | output | 1 | Sticky receive event |
| evt_busy | output | 1 | Sticky busy event |
| irq | output | 1 | Masked interrupt |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write |
| host_sel | input | 1 | 0 descriptor, 1 buffer byte |
| host_addr | input | DAW | Descriptor index or byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle later |

## Verification
The hardest case to reach from the ports is a continuous-mode descriptor reused on a second trip round the ring. Getting there needs every other descriptor in the ring closed once and then handed back by the host. The bench walks the whole ring and raises the length limit so that one slot fills completely. This carries the engine back to the continuous-mode descriptor, where a break closes its refilled buffer. A second hard case is an idle run broken by bytes. Idle strobes are interleaved with single bytes so that no run reaches the limit, and the untouched descriptor is read back before the final strobe closes it.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int BIT_E  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_I  = 2;
  localparam int BIT_CM = 3;
  localparam int BIT_ID = 8;
  localparam int BIT_BR = 9;
  localparam int BIT_FR = 10;
  localparam int BIT_PR = 11;
  localparam int BIT_OV = 12;

  typedef enum logic {ST_RUN, ST_CLOSE} eng_state_e;

  typedef struct packed {
    logic ov;
    logic pr;
    logic fr;
    logic br;
    logic id;
  } close_cause_t;
endpackage

// File: rtl/rxbd_store.sv
module rxbd_store #(
  parameter int NUM_BD    = 8,
  parameter int BUF_BYTES = 16,
  localparam int BDW  = $clog2(NUM_BD),
  localparam int OFFW = $clog2(BUF_BYTES),
  localparam int DAW  = BDW + OFFW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BDW-1:0] eng_idx,
  output logic [31:0]    eng_desc,
  input  logic           eng_desc_we,
  input  logic [31:0]    eng_desc_wd,
  input  logic           eng_dat_we,
  input  logic [DAW-1:0] eng_dat_addr,
  input  logic [7:0]     eng_dat_wd,
  input  logic           host_en,
  input  logic           host_we,
  input  logic           host_sel,
  input  logic [DAW-1:0] host_addr,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata
);
  logic [31:0] desc_mem [NUM_BD];
  logic [7:0]  data_mem [NUM_BD*BUF_BYTES];

  logic host_desc_wr, host_data_wr;
  assign host_desc_wr = host_en && host_we && !host_sel;
  assign host_data_wr = host_en && host_we && host_sel;
  assign eng_desc     = desc_mem[eng_idx];

  // Host write is applied last, so it wins on a same-entry collision.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BD; i++) desc_mem[i] <= '0;
    end else begin
      if (eng_desc_we)  desc_mem[eng_idx] <= eng_desc_wd;
      if (host_desc_wr) desc_mem[host_addr[BDW-1:0]] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (eng_dat_we)   data_mem[eng_dat_addr] <= eng_dat_wd;
    if (host_data_wr) data_mem[host_addr] <= host_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_en && !host_we) begin
      host_rdata <= host_sel ? {24'b0, data_mem[host_addr]}
                             : desc_mem[host_addr[BDW-1:0]];
    end
  end
endmodule

// File: rtl/rxbd_idle.sv
module rxbd_idle #(
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           idle_in,
  input  logic           brk_in,
  input  logic           byte_taken,
  input  logic           idle_svc,
  input  logic           brk_svc,
  input  logic [IDW-1:0] idle_limit,
  output logic           idle_hit,
  output logic           brk_pend
);
  logic [IDW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (byte_taken || idle_svc) begin
      idle_cnt <= '0;
    end else if (idle_in && idle_cnt != '1) begin
      idle_cnt <= idle_cnt + IDW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       brk_pend <= 1'b0;
    else if (brk_in)  brk_pend <= 1'b1;
    else if (brk_svc) brk_pend <= 1'b0;
  end

  assign idle_hit = (idle_limit != '0) && (idle_cnt >= idle_limit);
endmodule

// File: rtl/rxbd_events.sv
module rxbd_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_rx,
  input  logic       set_busy,
  input  logic [1:0] clr,
  input  logic [1:0] mask,
  output logic       evt_rx,
  output logic       evt_busy,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_rx   <= 1'b0;
      evt_busy <= 1'b0;
    end else begin
      if (set_rx)        evt_rx <= 1'b1;
      else if (clr[0])   evt_rx <= 1'b0;
      if (set_busy)      evt_busy <= 1'b1;
      else if (clr[1])   evt_busy <= 1'b0;
    end
  end

  assign irq = (evt_rx && mask[0]) || (evt_busy && mask[1]);
endmodule

// File: rtl/rxbd_rx_engine.sv
module rxbd_rx_engine
  import rxbd_pkg::*;
#(
  parameter int NUM_BD    = 8,
  parameter int BUF_BYTES = 16,
  parameter int IDW       = 8,
  localparam int BDW  = $clog2(NUM_BD),
  localparam int OFFW = $clog2(BUF_BYTES),
  localparam int DAW  = BDW + OFFW,
  localparam int LW   = $clog2(BUF_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [7:0]     in_data,
  input  logic           in_frame_err,
  input  logic           in_parity_err,
  input  logic           in_overrun,
  input  logic           rx_break,
  input  logic           rx_idle,
  input  logic [BDW-1:0] ring_base,
  input  logic [LW-1:0]  max_len,
  input  logic [IDW-1:0] idle_limit,
  input  logic [1:0]     irq_mask,
  input  logic [1:0]     evt_clr,
  output logic           evt_rx,
  output logic           evt_busy,
  output logic           irq,
  input  logic           host_en,
  input  logic           host_we,
  input  logic           host_sel,
  input  logic [DAW-1:0] host_addr,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata
);
  eng_state_e   state;
  logic [BDW-1:0] cur_bd;
  logic [LW-1:0]  cnt, pend_len, eff_max, next_cnt;
  logic           ov_acc;
  close_cause_t   pend_cause;

  logic [31:0] desc, close_wd;
  logic        eng_desc_we, eng_dat_we;
  logic        take, have_room, byte_store, byte_close;
  logic        brk_go, brk_store, idle_go, busy_hit;
  logic        idle_hit, brk_pend;
  logic [BDW-1:0] nxt_bd;
  logic        unused_desc;

  assign unused_desc = ^desc[31:4];

  assign eff_max = (max_len == '0 || max_len > LW'(BUF_BYTES)) ? LW'(BUF_BYTES) : max_len;
  assign in_ready   = (state == ST_RUN);
  assign take       = in_valid && in_ready;
  assign have_room  = desc[BIT_E];
  assign next_cnt   = cnt + LW'(1);
  assign byte_store = take && have_room;
  assign byte_close = byte_store && (in_frame_err || in_parity_err || next_cnt >= eff_max);
  assign brk_go     = in_ready && !in_valid && brk_pend;
  assign brk_store  = brk_go && have_room;
  assign idle_go    = in_ready && !in_valid && !brk_pend && idle_hit && (cnt != '0);
  assign busy_hit   = (take || brk_go) && !have_room;
  assign eng_dat_we = byte_store;
  assign eng_desc_we = (state == ST_CLOSE);

  assign nxt_bd = desc[BIT_W] ? ring_base
                : (cur_bd == BDW'(NUM_BD - 1)) ? '0 : cur_bd + BDW'(1);

  always_comb begin
    close_wd          = '0;
    close_wd[31:16]   = 16'(pend_len);
    close_wd[BIT_W]   = desc[BIT_W];
    close_wd[BIT_I]   = desc[BIT_I];
    close_wd[BIT_CM]  = desc[BIT_CM];
    close_wd[BIT_E]   = desc[BIT_CM] && !(pend_cause.ov || pend_cause.pr || pend_cause.fr);
    close_wd[BIT_ID]  = pend_cause.id;
    close_wd[BIT_BR]  = pend_cause.br;
    close_wd[BIT_FR]  = pend_cause.fr;
    close_wd[BIT_PR]  = pend_cause.pr;
    close_wd[BIT_OV]  = pend_cause.ov;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      cur_bd     <= ring_base;
      cnt        <= '0;
      ov_acc     <= 1'b0;
      pend_len   <= '0;
      pend_cause <= '0;
    end else if (state == ST_RUN) begin
      if (byte_store) begin
        cnt    <= next_cnt;
        ov_acc <= ov_acc | in_overrun;
        if (byte_close) begin
          pend_cause <= '{ov: ov_acc | in_overrun, pr: in_parity_err,
                          fr: in_frame_err, br: 1'b0, id: 1'b0};
          pend_len   <= next_cnt;
          state      <= ST_CLOSE;
        end
      end else if (brk_store) begin
        pend_cause <= '{ov: ov_acc, pr: 1'b0, fr: 1'b0, br: 1'b1, id: 1'b0};
        pend_len   <= cnt;
        state      <= ST_CLOSE;
      end else if (idle_go) begin
        pend_cause <= '{ov: ov_acc, pr: 1'b0, fr: 1'b0, br: 1'b0, id: 1'b1};
        pend_len   <= cnt;
        state      <= ST_CLOSE;
      end
    end else begin
      cur_bd <= nxt_bd;
      cnt    <= '0;
      ov_acc <= 1'b0;
      state  <= ST_RUN;
    end
  end

  rxbd_store #(.NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES)) u_store (
    .clk, .rst_n,
    .eng_idx(cur_bd), .eng_desc(desc),
    .eng_desc_we, .eng_desc_wd(close_wd),
    .eng_dat_we, .eng_dat_addr({cur_bd, cnt[OFFW-1:0]}), .eng_dat_wd(in_data),
    .host_en, .host_we, .host_sel, .host_addr, .host_wdata, .host_rdata
  );

  rxbd_idle #(.IDW(IDW)) u_idle (
    .clk, .rst_n,
    .idle_in(rx_idle), .brk_in(rx_break), .byte_taken(take),
    .idle_svc(idle_go), .brk_svc(brk_go), .idle_limit,
    .idle_hit, .brk_pend
  );

  rxbd_events u_events (
    .clk, .rst_n,
    .set_rx(eng_desc_we && desc[BIT_I]), .set_busy(busy_hit),
    .clr(evt_clr), .mask(irq_mask),
    .evt_rx, .evt_busy, .irq
  );
endmodule

// File: rtl/rxbd_checker.sv
module rxbd_checker #(
  parameter int BUF_BYTES = 16,
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          evt_rx,
  input logic          desc_we,
  input logic [31:0]   desc_wd,
  input logic          dat_we,
  input logic [LW-1:0] cnt
);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(BUF_BYTES));

  a_r1_store_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we |-> (in_valid && in_ready));

  a_r4_err_clears_e: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && (desc_wd[10] || desc_wd[11] || desc_wd[12])) |-> !desc_wd[0]);

  a_r5_rx_from_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_rx) |-> $past(desc_we));

  a_r12_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> in_ready);

  a_r12_single_close_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |=> !desc_we);
endmodule

bind rxbd_rx_engine rxbd_checker #(.BUF_BYTES(BUF_BYTES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .evt_rx(evt_rx), .desc_we(eng_desc_we), .desc_wd(close_wd),
  .dat_we(eng_dat_we), .cnt(cnt)
);

// File: tb/test_rxbd_rx_engine.sv
module test_rxbd_rx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_BD = 8;
  localparam int BUF_BYTES = 16;
  localparam int IDW = 8;
  localparam int BDW = $clog2(NUM_BD);
  localparam int DAW = BDW + $clog2(BUF_BYTES);
  localparam int LW = $clog2(BUF_BYTES + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, in_frame_err = 0, in_parity_err = 0, in_overrun = 0;
  logic [7:0] in_data = '0;
  logic rx_break = 0, rx_idle = 0;
  logic [BDW-1:0] ring_base = '0;
  logic [LW-1:0] max_len = LW'(4);
  logic [IDW-1:0] idle_limit = IDW'(3);
  logic [1:0] irq_mask = 2'b01, evt_clr = 2'b00;
  logic evt_rx, evt_busy, irq;
  logic host_en = 0, host_we = 0, host_sel = 0;
  logic [DAW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  typedef struct { string req; bit sel; int addr; logic [31:0] val; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbd_rx_engine #(.NUM_BD(NUM_BD), .BUF_BYTES(BUF_BYTES), .IDW(IDW)) i_rxbd_rx_engine (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_frame_err, .in_parity_err,
    .in_overrun, .rx_break, .rx_idle, .ring_base, .max_len, .idle_limit, .irq_mask,
    .evt_clr, .evt_rx, .evt_busy, .irq, .host_en, .host_we, .host_sel, .host_addr,
    .host_wdata, .host_rdata
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input bit sel, input int addr, input logic [31:0] d);
    @(negedge clk);
    host_en = 1; host_we = 1; host_sel = sel; host_addr = DAW'(addr); host_wdata = d;
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic host_rd(input bit sel, input int addr, output logic [31:0] d);
    @(negedge clk);
    host_en = 1; host_we = 0; host_sel = sel; host_addr = DAW'(addr);
    @(negedge clk);
    host_en = 0;
    d = host_rdata;
  endtask

  task automatic expect_item(input string req, input bit sel, input int addr, input logic [31:0] v);
    exp_t e;
    e.req = req; e.sel = sel; e.addr = addr; e.val = v;
    exp_q.push_back(e);
  endtask

  // Driver: offers one byte, waits for the handshake, queues the expected stored byte.
  task automatic send_byte(input logic [7:0] d, input logic fr, input logic pr,
                           input logic ov, input int addr, input string req);
    @(negedge clk);
    in_valid = 1; in_data = d; in_frame_err = fr; in_parity_err = pr; in_overrun = ov;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_frame_err = 0; in_parity_err = 0; in_overrun = 0;
    if (addr >= 0) expect_item(req, 1'b1, addr, {24'b0, d});
  endtask

  task automatic strobe(input bit brk);
    @(negedge clk);
    if (brk) rx_break = 1; else rx_idle = 1;
    @(negedge clk);
    rx_break = 0; rx_idle = 0;
  endtask

  task automatic clear_events();
    @(negedge clk); evt_clr = 2'b11;
    @(negedge clk); evt_clr = 2'b00;
  endtask

  // Monitor: lets the engine settle, then pops every queued item and compares it via the host port.
  task automatic drain();
    logic [31:0] r;
    repeat (3) @(negedge clk);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      host_rd(e.sel, e.addr, r);
      chk(e.req, r, e.val);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk("R12 reset in_ready", {31'b0, in_ready}, 32'd1);
    chk("R5 reset events", {29'b0, evt_rx, evt_busy, irq}, 32'd0);
    host_rd(1'b0, 0, r);
    chk("R13 reset descriptor", r, 32'h0);

    // Ring of four: descriptors 0..3 empty+interrupt, wrap on 3
    host_wr(0, 0, 32'h0005); host_wr(0, 1, 32'h0005);
    host_wr(0, 2, 32'h0005); host_wr(0, 3, 32'h0007);

    // R2 length close and R12 back-pressure
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i), 0, 0, 0, i, "R1 R13 byte store");
    chk("R12 ready low after close", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R12 ready back", {31'b0, in_ready}, 32'd1);
    chk("R5 evt_rx set", {31'b0, evt_rx}, 32'd1);
    chk("R5 irq on rx", {31'b0, irq}, 32'd1);
    expect_item("R2 length close", 0, 0, 32'h0004_0004);
    drain();
    clear_events();
    chk("R5 irq cleared", {31'b0, irq}, 32'd0);

    // R7 parity
    send_byte(8'hB0, 0, 1, 0, 16, "R7 byte kept");
    expect_item("R7 parity close", 0, 1, 32'h0001_0804);
    drain();

    // R8 overrun then R6 framing
    send_byte(8'hC0, 0, 0, 0, 32, "R8 byte");
    send_byte(8'hC1, 0, 0, 1, 33, "R8 overrun byte kept");
    send_byte(8'hC2, 1, 0, 0, 34, "R6 frame byte last");
    expect_item("R6 R8 frame overrun close", 0, 2, 32'h0003_1404);
    drain();

    // R9 break with one byte, R3 wrap on descriptor 3
    send_byte(8'hD0, 0, 0, 0, 48, "R9 byte");
    strobe(1);
    expect_item("R9 R3 break close", 0, 3, 32'h0001_0206);
    drain();
    clear_events();

    // R11 busy: wrapped to 0 which is not empty
    irq_mask = 2'b10;
    send_byte(8'h99, 0, 0, 0, -1, "R11");
    @(negedge clk);
    chk("R11 busy event", {31'b0, evt_busy}, 32'd1);
    chk("R5 irq on busy mask", {31'b0, irq}, 32'd1);
    expect_item("R11 descriptor untouched", 0, 0, 32'h0004_0004);
    expect_item("R11 byte dropped", 1, 0, 32'h0000_00A0);
    drain();
    irq_mask = 2'b01;
    clear_events();

    // R11 retry after host hands back; R10 idle close; R4 continuous keeps E
    host_wr(0, 0, 32'h0009);
    host_wr(0, 1, 32'h0005);
    send_byte(8'hE0, 0, 0, 0, 0, "R11 retry stored");
    repeat (3) strobe(0);
    expect_item("R10 R4 idle close keeps E", 0, 0, 32'h0001_0109);
    drain();
    chk("R5 no event without I", {31'b0, evt_rx}, 32'd0);

    // R10 idle run restarted by bytes
    strobe(0); strobe(0);
    send_byte(8'hF0, 0, 0, 0, 16, "R10 byte");
    strobe(0); strobe(0);
    send_byte(8'hF1, 0, 0, 0, 17, "R10 byte");
    strobe(0); strobe(0);
    expect_item("R10 no close before limit", 0, 1, 32'h0000_0005);
    drain();
    strobe(0);
    expect_item("R10 idle close", 0, 1, 32'h0002_0104);
    drain();

    // R4 error clears E despite continuous mode
    host_wr(0, 2, 32'h0009);
    send_byte(8'h60, 1, 0, 0, 32, "R4 frame byte");
    expect_item("R4 error clears E", 0, 2, 32'h0001_0408);
    drain();

    // R2 max_len 0 means full slot; R3 wrap; R4 reuse of continuous buffer
    max_len = '0;
    host_wr(0, 3, 32'h0003);
    for (int i = 0; i < 16; i++) send_byte(8'h40 + 8'(i), 0, 0, 0, 48 + i, "R1 full slot byte");
    expect_item("R2 full slot close", 0, 3, 32'h0010_0002);
    drain();
    send_byte(8'h70, 0, 0, 0, 0, "R4 overwrite");
    send_byte(8'h71, 0, 0, 0, 1, "R4 overwrite");
    strobe(1);
    expect_item("R4 R9 second pass", 0, 0, 32'h0002_0209);
    drain();

    // R9 zero-length break
    host_wr(0, 1, 32'h0001);
    strobe(1);
    expect_item("R9 empty break", 0, 1, 32'h0000_0200);
    drain();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule